// File: doc/BRIEF.md
# GPIO Edge and Level Interrupt Controller

This block manages banks of 32 general-purpose pins and raises a single interrupt request from input transitions or input levels. Each pin can be driven as an output or left as an input, and each has its own polarity control. Polarity inversion applies to the driven value and to the observed value. Every pin has four independent trigger enables: rising edge, falling edge, high level and low level. A pending event shows as a per-pin status bit. A separate edge record shows whether the last enabled edge on that pin was a rising or a falling one.

Inputs are brought into the clock domain through a two-flop synchronizer. Edges are found by comparing the synchronized sample with the sample from one cycle earlier. Edge events are sticky until software clears them by writing 1. Level events are not stored: they follow the live pin for as long as the enable is set. The interrupt request is the OR of every status bit in every bank. Software reaches all of this through a flat register port. The upper address bits pick the bank and the low four bits pick the register: 0 input data (read-only), 1 output data, 2 output enable, 3 polarity, 4 rising enable, 5 falling enable, 6 high-level enable, 7 low-level enable, 8 status (write 1 to clear), 9 edge record (read-only).

Top module: `gpio_evt_irq`

## Requirements
- R1: After reset every register reads 0, `irqOut` is 0 and `padOut` and `padOe` are all 0.
- R2: With a pin's rising enable set, a seen 0-to-1 transition sets that pin's status bit, and no other bit, within four clock cycles of the pin changing.
- R3: With a pin's falling enable set, a seen 1-to-0 transition sets that pin's status bit within four clock cycles.
- R4: Edge status bits stay set until a write to register 8 with a 1 in that bit position. Writing 0 bits leaves them set.
- R5: With a high (low) level enable set, the status bit reads 1 exactly while the seen pin value is 1 (0), and it drops when the condition ends, without any clear write.
- R6: When both level enables of a pin are set, the high-level enable wins and the low-level condition is ignored.
- R7: The edge record bit becomes 1 on an enabled rising event and 0 on an enabled falling event. Otherwise it holds.
- R8: A polarity bit of 1 inverts the pin for the input-data read, for edge and level detection and for `padOut`. Changing polarity alone never produces an edge event.
- R9: `irqOut` is 1 exactly when some status bit in any bank reads 1.
- R10: `padOut` for bank b, bit i is output data XOR polarity, and `padOe` equals the output-enable register, each taking effect one cycle after the write.
- R11: Writes to a bank index at or above the bank count, to an unused register select (10 to 15) or to the read-only registers 0 and 9 change nothing. Reads of such locations return 0 (register 0 returns the seen inputs).
- R12: A transition whose edge type is not enabled leaves the status bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 6 | Bank index in [5:4], register select in [3:0] |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| padIn | input | 96 | Pin input values, asynchronous |
| padOut | output | 96 | Pin drive values |
| padOe | output | 96 | Pin output enables |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench sweeps a rising edge across every one of the 96 pins and checks that exactly one bit in exactly one bank lights. A design with a wrong bank decode or bit offset would light a neighbour or nothing. Each swept pin is then lowered with only the rising enable set, which catches status that does not depend on the edge type. A clear with 0 bits is tried before a clear with 1, which catches a register that simply overwrites status. Further checks drive both level enables on one pin, flip polarity under a pending enable (a design that compares raw samples across the polarity change would raise a false edge), and write to the fourth bank index and to read-only locations, where a loose decoder would alias onto a real bank.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_DIN  = 4'd0,
    SEL_DOUT = 4'd1,
    SEL_DIR  = 4'd2,
    SEL_POL  = 4'd3,
    SEL_RISE = 4'd4,
    SEL_FALL = 4'd5,
    SEL_HIGH = 4'd6,
    SEL_LOW  = 4'd7,
    SEL_STAT = 4'd8,
    SEL_EDGE = 4'd9
  } regSel_e;

  // Strobes from the register decoder to one bank datapath.
  typedef struct packed {
    logic    wrDout;
    logic    wrDir;
    logic    wrPol;
    logic    wrRise;
    logic    wrFall;
    logic    wrHigh;
    logic    wrLow;
    logic    clrStat;
    logic    rdEn;
    regSel_e rdSel;
  } bankStrobe_t;

endpackage

// File: rtl/gpio_irq_regdec.sv
module gpio_irq_regdec
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 6
) (
  input  logic                         regWr,
  input  logic [ADDR_W-1:0]            regAddr,
  output bankStrobe_t [NUM_BANKS-1:0]  strb
);

  localparam int BIDX_W = ADDR_W - SEL_W;

  logic [BIDX_W-1:0] bankIdx;
  regSel_e           sel;

  assign bankIdx = regAddr[ADDR_W-1:SEL_W];
  assign sel     = regSel_e'(regAddr[SEL_W-1:0]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    logic hit;
    logic wrHit;
    assign hit   = (bankIdx == BIDX_W'(b));
    assign wrHit = regWr && hit;

    always_comb begin
      strb[b]         = '0;
      strb[b].rdEn    = hit;
      strb[b].rdSel   = sel;
      strb[b].wrDout  = wrHit && (sel == SEL_DOUT);
      strb[b].wrDir   = wrHit && (sel == SEL_DIR);
      strb[b].wrPol   = wrHit && (sel == SEL_POL);
      strb[b].wrRise  = wrHit && (sel == SEL_RISE);
      strb[b].wrFall  = wrHit && (sel == SEL_FALL);
      strb[b].wrHigh  = wrHit && (sel == SEL_HIGH);
      strb[b].wrLow   = wrHit && (sel == SEL_LOW);
      strb[b].clrStat = wrHit && (sel == SEL_STAT);
    end
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strb,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] padIn,
  output logic [BANK_W-1:0] padOut,
  output logic [BANK_W-1:0] padOe,
  output logic [BANK_W-1:0] statVec,
  output logic [BANK_W-1:0] rdData
);

  logic [BANK_W-1:0] syncA, syncB, prevRaw;
  logic [BANK_W-1:0] doutR, dirR, polR;
  logic [BANK_W-1:0] riseEn, fallEn, highEn, lowEn;
  logic [BANK_W-1:0] stickyR, edgeRecR;
  logic [BANK_W-1:0] seenNow, seenPrev;
  logic [BANK_W-1:0] riseHit, fallHit, levelHit, clrMask;

  // Two-flop synchronizer plus one history stage (raw values).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      prevRaw <= '0;
    end else begin
      syncA   <= padIn;
      syncB   <= syncA;
      prevRaw <= syncB;
    end
  end

  // Both samples pass through the current polarity, so a polarity
  // change alone never looks like a transition.
  assign seenNow  = syncB ^ polR;
  assign seenPrev = prevRaw ^ polR;
  assign riseHit  = seenNow & ~seenPrev & riseEn;
  assign fallHit  = ~seenNow & seenPrev & fallEn;
  assign levelHit = (highEn & seenNow) | (lowEn & ~highEn & ~seenNow);
  assign clrMask  = strb.clrStat ? wdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doutR  <= '0;
      dirR   <= '0;
      polR   <= '0;
      riseEn <= '0;
      fallEn <= '0;
      highEn <= '0;
      lowEn  <= '0;
    end else begin
      if (strb.wrDout) doutR  <= wdata;
      if (strb.wrDir)  dirR   <= wdata;
      if (strb.wrPol)  polR   <= wdata;
      if (strb.wrRise) riseEn <= wdata;
      if (strb.wrFall) fallEn <= wdata;
      if (strb.wrHigh) highEn <= wdata;
      if (strb.wrLow)  lowEn  <= wdata;
    end
  end

  // Sticky edge status: a new event wins over a same-cycle clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyR  <= '0;
      edgeRecR <= '0;
    end else begin
      stickyR  <= (stickyR & ~clrMask) | riseHit | fallHit;
      edgeRecR <= (edgeRecR & ~fallHit) | riseHit;
    end
  end

  assign statVec = stickyR | levelHit;
  assign padOut  = doutR ^ polR;
  assign padOe   = dirR;

  always_comb begin
    rdData = '0;
    if (strb.rdEn) begin
      case (strb.rdSel)
        SEL_DIN:  rdData = seenNow;
        SEL_DOUT: rdData = doutR;
        SEL_DIR:  rdData = dirR;
        SEL_POL:  rdData = polR;
        SEL_RISE: rdData = riseEn;
        SEL_FALL: rdData = fallEn;
        SEL_HIGH: rdData = highEn;
        SEL_LOW:  rdData = lowEn;
        SEL_STAT: rdData = statVec;
        SEL_EDGE: rdData = edgeRecR;
        default:  rdData = '0;
      endcase
    end
  end

  // A newly set sticky bit needs an edge enable in the cycle before.
  p_edge_gate_r12: assert property (@(posedge clk) disable iff (!rstN)
    ((stickyR & ~$past(stickyR)) & ~$past(riseEn | fallEn)) == '0);

  // A pending edge bit that was not cleared stays pending.
  p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stickyR & $past(stickyR & ~clrMask)) == $past(stickyR & ~clrMask));

  // A fresh event raised by a rising transition leaves the record at 1.
  p_edge_rec_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((stickyR & ~$past(stickyR) & $past(seenNow & ~seenPrev)) & ~edgeRecR) == '0);

  // An output-enable write shows on the pads one cycle later.
  p_dir_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.wrDir) |-> (padOe == $past(wdata)));

endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  parameter int ADDR_W    = BIDX_W + SEL_W,
  parameter int PINS      = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BANK_W-1:0] regWdata,
  output logic [BANK_W-1:0] regRdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic              irqOut
);

  bankStrobe_t [NUM_BANKS-1:0] strb;
  logic [NUM_BANKS-1:0][BANK_W-1:0] bankRd;
  logic [NUM_BANKS-1:0][BANK_W-1:0] bankStat;

  gpio_irq_regdec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) dec_i (
    .regWr   (regWr),
    .regAddr (regAddr),
    .strb    (strb)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_irq_bank #(.BANK_W(BANK_W)) bank_i (
      .clk     (clk),
      .rstN    (rstN),
      .strb    (strb[b]),
      .wdata   (regWdata),
      .padIn   (padIn[b*BANK_W +: BANK_W]),
      .padOut  (padOut[b*BANK_W +: BANK_W]),
      .padOe   (padOe[b*BANK_W +: BANK_W]),
      .statVec (bankStat[b]),
      .rdData  (bankRd[b])
    );
  end

  always_comb begin
    regRdata = '0;
    irqOut   = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      regRdata = regRdata | bankRd[b];
      irqOut   = irqOut | (|bankStat[b]);
    end
  end

  // First cycle out of reset: no request and no pad driven.
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (!irqOut && padOe == '0 && padOut == '0));

endmodule

// File: tb/gpio_evt_irq_tb_top.sv
module gpio_evt_irq_tb_top;
  localparam int NB = 3, BW = 32, PINS = 96, AW = 6;

  logic clk = 0, rstN = 0, regWr = 0;
  logic [AW-1:0] regAddr = '0;
  logic [BW-1:0] regWdata = '0, regRdata;
  logic [PINS-1:0] padIn = '0, padOut, padOe;
  logic irqOut;
  int nChk = 0, nFail = 0;
  logic [31:0] rv;

  gpio_evt_irq dut_i (.clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .irqOut(irqOut));

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wrReg(int b, int s, logic [31:0] d);
    @(negedge clk);
    regWr = 1; regAddr = {b[1:0], s[3:0]}; regWdata = d;
    @(negedge clk);
    regWr = 0;
  endtask

  task automatic rdReg(int b, int s, output logic [31:0] d);
    @(negedge clk);
    regAddr = {b[1:0], s[3:0]};
    #1 d = regRdata;
  endtask

  task automatic setPin(int p, logic v);
    @(negedge clk);
    padIn[p] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic allBanks(int s, logic [31:0] d);
    for (int b = 0; b < NB; b++) wrReg(b, s, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++; nChk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < 10; s++) begin rdReg(b, s, rv); chk("R1 reg", rv, 0); end
    chk("R1 irq", {31'd0, irqOut}, 0);
    chk("R1 oe", padOe[31:0] | padOe[63:32] | padOe[95:64], 0);
    chk("R1 out", padOut[31:0] | padOut[63:32] | padOut[95:64], 0);

    // R10 output drive and enable
    wrReg(2, 2, 32'hA5A5_A5A5);
    wrReg(2, 1, 32'h1234_5678);
    chk("R10 oe", padOe[95:64], 32'hA5A5_A5A5);
    chk("R10 out", padOut[95:64], 32'h1234_5678);
    chk("R10 other bank", padOe[63:32], 0);

    // R11 ignored writes
    wrReg(3, 1, 32'hFFFF_FFFF);
    rdReg(3, 1, rv); chk("R11 bank3 read", rv, 0);
    chk("R11 no alias", padOut[31:0], 0);
    wrReg(0, 12, 32'hFFFF_FFFF);
    rdReg(0, 12, rv); chk("R11 unused sel", rv, 0);
    wrReg(2, 0, 32'hFFFF_FFFF);
    rdReg(2, 0, rv); chk("R11 din read-only", rv, 0);
    wrReg(2, 9, 32'hFFFF_FFFF);
    rdReg(2, 9, rv); chk("R11 edge read-only", rv, 0);
    for (int s = 3; s < 9; s++) begin rdReg(0, s, rv); chk("R11 bank0 intact", rv, 0); end

    // R2/R4/R7/R9/R12 sweep over every pin
    allBanks(4, 32'hFFFF_FFFF);
    for (int p = 0; p < PINS; p++) begin
      setPin(p, 1'b1);
      for (int b = 0; b < NB; b++) begin
        rdReg(b, 8, rv);
        chk("R2 rise status", rv, (b == p / 32) ? (32'd1 << (p % 32)) : 32'd0);
      end
      chk("R9 irq set", {31'd0, irqOut}, 1);
      rdReg(p / 32, 9, rv); chk("R7 rise record", rv[p % 32], 1);
      wrReg(p / 32, 8, ~(32'd1 << (p % 32)));
      rdReg(p / 32, 8, rv); chk("R4 zero bits keep", rv, 32'd1 << (p % 32));
      wrReg(p / 32, 8, 32'd1 << (p % 32));
      rdReg(p / 32, 8, rv); chk("R4 clear", rv, 0);
      chk("R9 irq clear", {31'd0, irqOut}, 0);
      setPin(p, 1'b0);
      rdReg(p / 32, 8, rv); chk("R12 fall not enabled", rv, 0);
    end

    // R3/R7 falling edges
    allBanks(4, 0);
    allBanks(5, 32'hFFFF_FFFF);
    for (int p = 0; p < PINS; p += 7) begin
      setPin(p, 1'b1);
      rdReg(p / 32, 8, rv); chk("R12 rise not enabled", rv, 0);
      setPin(p, 1'b0);
      rdReg(p / 32, 8, rv); chk("R3 fall status", rv, 32'd1 << (p % 32));
      rdReg(p / 32, 9, rv); chk("R7 fall record", rv[p % 32], 0);
      wrReg(p / 32, 8, 32'hFFFF_FFFF);
    end
    allBanks(5, 0);

    // R5 level enables
    wrReg(1, 6, 32'd1 << 3);
    setPin(35, 1'b1);
    rdReg(1, 8, rv); chk("R5 high level", rv, 32'd1 << 3);
    chk("R9 level irq", {31'd0, irqOut}, 1);
    setPin(35, 1'b0);
    rdReg(1, 8, rv); chk("R5 high level drop", rv, 0);
    chk("R9 level irq drop", {31'd0, irqOut}, 0);
    wrReg(1, 6, 0);
    wrReg(2, 7, 32'd1);
    repeat (2) @(negedge clk);
    rdReg(2, 8, rv); chk("R5 low level", rv, 1);
    setPin(64, 1'b1);
    rdReg(2, 8, rv); chk("R5 low level drop", rv, 0);
    wrReg(2, 7, 0);

    // R6 both level enables
    wrReg(0, 6, 32'd1 << 5);
    wrReg(0, 7, 32'd1 << 5);
    repeat (2) @(negedge clk);
    rdReg(0, 8, rv); chk("R6 low ignored", rv, 0);
    setPin(5, 1'b1);
    rdReg(0, 8, rv); chk("R6 high wins", rv, 32'd1 << 5);
    wrReg(0, 6, 0); wrReg(0, 7, 0);
    setPin(5, 1'b0);

    // R8 polarity
    wrReg(0, 4, 32'd1 << 4);
    wrReg(0, 3, 32'h0000_00F0);
    wrReg(0, 1, 32'h0000_000F);
    chk("R8 out inverted", padOut[31:0], 32'h0000_00FF);
    repeat (3) @(negedge clk);
    rdReg(0, 8, rv); chk("R8 no edge from polarity", rv, 0);
    rdReg(0, 0, rv); chk("R8 din inverted", rv, 32'h0000_00F0);
    setPin(4, 1'b1);
    rdReg(0, 8, rv); chk("R8 raw rise seen as fall", rv, 0);
    setPin(4, 1'b0);
    rdReg(0, 8, rv); chk("R8 raw fall seen as rise", rv, 32'd1 << 4);
    wrReg(0, 8, 32'hFFFF_FFFF);
    wrReg(0, 3, 0); wrReg(0, 4, 0);

    // R9 combined across banks
    wrReg(0, 4, 32'd1 << 1);
    wrReg(2, 4, 32'd1 << 6);
    @(negedge clk); padIn[1] = 1; padIn[70] = 1;
    repeat (4) @(negedge clk);
    chk("R9 two banks", {31'd0, irqOut}, 1);
    wrReg(0, 8, 32'd1 << 1);
    chk("R9 one left", {31'd0, irqOut}, 1);
    wrReg(2, 8, 32'd1 << 6);
    chk("R9 none left", {31'd0, irqOut}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule